// File: doc/BRIEF.md
# Shadow-Buffered PWM Timer with Output Override

This block is a single-slope PWM timer. A free-running up-counter climbs from zero to a programmable period value and then returns to zero. Each compare channel produces a waveform that is high while the count is below its compare value. Eight waveform outputs take their level from these channel results. An override register can pin any output to a fixed level in place of its waveform.

Software changes duty cycles and overrides through shadow registers. A shadow write marks the shadow as pending. At the next wrap of the counter, every pending shadow moves into its working register at the same moment. A new duty cycle and a new override therefore start on the same edge, with no partial period in which only one of them has changed. A lock bit, set and cleared through two separate write addresses, holds all such moves back while software prepares a set of changes. Working registers can also be written directly, and such a write takes hold on the next clock.

The register map is:

- 0x0: period
- 0x1: control
- 0x2: lock-set
- 0x3: lock-clear
- 0x4: active override
- 0x5: override shadow
- 0x6: count, read only
- 0x7: status, read only
- 0x8 + n: active compare for channel n
- 0xC + n: compare shadow for channel n

Top module: `pwm_shadow_pattern`

## Requirements
- R1: The count runs 0, 1, ... up to the period value (address 0x0) and then returns to 0, so a period P gives P+1 clocks per cycle. The count can be read at address 0x6.
- R2: A channel waveform is high while count < active compare value, and low otherwise. A compare of 0 gives a low level for the whole cycle. A compare above the period gives a high level for the whole cycle.
- R3: A write to a compare shadow (0xC+n) or to the override shadow (0x5) sets its pending bit in the status port: bit n for compare n, bit NUM_CH for the override. The active register keeps its old value until a transfer takes place.
- R4: At the wrap from the period value to 0, each pending shadow is copied into its active register and its pending bit clears. All these copies are visible in the same clock in which the count reads 0.
- R5: At a wrap, an active register whose shadow is not pending keeps its value, including a value written directly.
- R6: Writing 1 in bit 0 at address 0x2 sets the lock, and writing 1 in bit 0 at address 0x3 clears it. A write with bit 0 at 0 to either address has no effect. The lock is shown in status bit NUM_CH+1.
- R7: A wrap that occurs while the lock is set transfers nothing, and the pending bits stay set. Pending values are committed at the first wrap after the lock clears.
- R8: In the override register, bit i (0-7) enables the override for output i and bit 8+i gives its level. An enabled output drives that level instead of its waveform.
- R9: With control bit 0 clear, output i follows channel i mod NUM_CH. With control bit 0 set, every output follows channel 0.
- R10: A direct write to an active compare (0x8+n) or to the active override (0x4) is visible from the next clock, and the matching shadow is not changed.
- R11: After reset, all registers, pending bits and the lock are 0, no override is enabled, and all outputs are low.
- R12: Every writable register reads back its value at its own address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 16 | Read data, combinational from rd_addr |
| status | output | NUM_CH+2 | Compare pending bits, override pending bit, lock bit |
| wave | output | NUM_OUT | Waveform outputs after override |

## Verification
A pending bit stuck at 1 or lost shows up in the status port in the cycle after the shadow write. It also shows up at the next wrap, because the compare readback and the waveforms then keep or take the wrong value. A transfer that ignores the lock, or that fires one clock off the wrap, is seen within one period: the active compare read, the pending bits or the output levels at count 0 differ from those expected. A wrong counter limit shows up as a wrong cycle length in the first measured period.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 16;

    localparam logic [ADDR_W-1:0] A_PERIOD   = 4'h0;
    localparam logic [ADDR_W-1:0] A_CTRL     = 4'h1;
    localparam logic [ADDR_W-1:0] A_LOCK_SET = 4'h2;
    localparam logic [ADDR_W-1:0] A_LOCK_CLR = 4'h3;
    localparam logic [ADDR_W-1:0] A_PAT_ACT  = 4'h4;
    localparam logic [ADDR_W-1:0] A_PAT_BUF  = 4'h5;
    localparam logic [ADDR_W-1:0] A_COUNT    = 4'h6;
    localparam logic [ADDR_W-1:0] A_STATUS   = 4'h7;
    localparam logic [ADDR_W-1:0] A_CMP_ACT  = 4'h8;
    localparam logic [ADDR_W-1:0] A_CMP_BUF  = 4'hC;
endpackage

// File: rtl/pwm_counter.sv
module pwm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        wrap  = (cnt_q >= period);
        cnt_d = wrap ? '0 : cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    // R1
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt_q == '0));

    // R1
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/pwm_shadow_reg.sv
module pwm_shadow_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shadow_we,
    input  logic         active_we,
    input  logic [W-1:0] wdata,
    input  logic         commit,
    output logic [W-1:0] active,
    output logic [W-1:0] shadow,
    output logic         pending
);
    typedef struct packed {
        logic [W-1:0] act;
        logic [W-1:0] shd;
        logic         vld;
    } sreg_t;

    sreg_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (commit && s_q.vld) begin
            s_d.act = s_q.shd;
            s_d.vld = 1'b0;
        end
        if (active_we) s_d.act = wdata;
        if (shadow_we) begin
            s_d.shd = wdata;
            s_d.vld = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active  = s_q.act;
    assign shadow  = s_q.shd;
    assign pending = s_q.vld;

    // R4
    commit_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && s_q.vld && !active_we) |=> (s_q.act == $past(s_q.shd)));

    // R7
    pending_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.vld) |-> $past(commit));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.vld && !active_we) |=> $stable(s_q.act));
endmodule

// File: rtl/pwm_wave_gen.sv
module pwm_wave_gen #(
    parameter int CNT_W   = 16,
    parameter int NUM_CH  = 4,
    parameter int NUM_OUT = 8
) (
    input  logic [CNT_W-1:0]        cnt,
    input  logic [NUM_CH*CNT_W-1:0] cmp_flat,
    input  logic                    route_all,
    input  logic [2*NUM_OUT-1:0]    pattern,
    output logic [NUM_OUT-1:0]      wave
);
    logic [NUM_CH-1:0] hit;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_cmp
        assign hit[c] = (cnt < cmp_flat[c*CNT_W +: CNT_W]);
    end

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
        localparam int SRC = o % NUM_CH;
        logic pwm_bit;
        assign pwm_bit = route_all ? hit[0] : hit[SRC];
        assign wave[o] = pattern[o] ? pattern[NUM_OUT+o] : pwm_bit;
    end
endmodule

// File: rtl/pwm_shadow_pattern.sv
module pwm_shadow_pattern
    import pwm_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int NUM_CH  = 4,
    parameter int NUM_OUT = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    output logic [NUM_CH+1:0]  status,
    output logic [NUM_OUT-1:0] wave
);
    localparam int PAT_W = 2 * NUM_OUT;

    typedef struct packed {
        logic [CNT_W-1:0] period;
        logic             lock;
        logic             route;
    } top_t;

    top_t top_d, top_q;

    logic [CNT_W-1:0]        cnt;
    logic                    wrap;
    logic                    commit;
    logic [CNT_W-1:0]        cmp_act [NUM_CH];
    logic [CNT_W-1:0]        cmp_shd [NUM_CH];
    logic [NUM_CH-1:0]       cmp_pend;
    logic [NUM_CH*CNT_W-1:0] cmp_flat;
    logic [PAT_W-1:0]        pat_act, pat_shd;
    logic                    pat_pend;

    always_comb begin
        top_d = top_q;
        if (wr_en) begin
            case (wr_addr)
                A_PERIOD:   top_d.period = wr_data[CNT_W-1:0];
                A_CTRL:     top_d.route  = wr_data[0];
                A_LOCK_SET: if (wr_data[0]) top_d.lock = 1'b1;
                A_LOCK_CLR: if (wr_data[0]) top_d.lock = 1'b0;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign commit = wrap && !top_q.lock;

    pwm_counter #(.CNT_W(CNT_W)) i_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .period (top_q.period),
        .cnt    (cnt),
        .wrap   (wrap)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic buf_we, act_we;
        assign buf_we = wr_en && (wr_addr == A_CMP_BUF + ADDR_W'(c));
        assign act_we = wr_en && (wr_addr == A_CMP_ACT + ADDR_W'(c));
        pwm_shadow_reg #(.W(CNT_W)) i_cmp (
            .clk       (clk),
            .rst_n     (rst_n),
            .shadow_we (buf_we),
            .active_we (act_we),
            .wdata     (wr_data[CNT_W-1:0]),
            .commit    (commit),
            .active    (cmp_act[c]),
            .shadow    (cmp_shd[c]),
            .pending   (cmp_pend[c])
        );
        assign cmp_flat[c*CNT_W +: CNT_W] = cmp_act[c];
    end

    pwm_shadow_reg #(.W(PAT_W)) i_pattern (
        .clk       (clk),
        .rst_n     (rst_n),
        .shadow_we (wr_en && (wr_addr == A_PAT_BUF)),
        .active_we (wr_en && (wr_addr == A_PAT_ACT)),
        .wdata     (wr_data[PAT_W-1:0]),
        .commit    (commit),
        .active    (pat_act),
        .shadow    (pat_shd),
        .pending   (pat_pend)
    );

    pwm_wave_gen #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .NUM_OUT(NUM_OUT)) i_wave (
        .cnt       (cnt),
        .cmp_flat  (cmp_flat),
        .route_all (top_q.route),
        .pattern   (pat_act),
        .wave      (wave)
    );

    assign status = {top_q.lock, pat_pend, cmp_pend};

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_PERIOD:  rd_data = DATA_W'(top_q.period);
            A_CTRL:    rd_data = DATA_W'(top_q.route);
            A_LOCK_SET: rd_data = DATA_W'(top_q.lock);
            A_PAT_ACT: rd_data = DATA_W'(pat_act);
            A_PAT_BUF: rd_data = DATA_W'(pat_shd);
            A_COUNT:   rd_data = DATA_W'(cnt);
            A_STATUS:  rd_data = DATA_W'(status);
            default: ;
        endcase
        for (int c = 0; c < NUM_CH; c++) begin
            if (rd_addr == A_CMP_ACT + ADDR_W'(c)) rd_data = DATA_W'(cmp_act[c]);
            if (rd_addr == A_CMP_BUF + ADDR_W'(c)) rd_data = DATA_W'(cmp_shd[c]);
        end
    end

    // R7
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (top_q.lock && wrap && !wr_en) |=> $stable(status[NUM_CH:0]));

    // R6
    lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_LOCK_SET && wr_data[0]) |=> status[NUM_CH+1]);

    // R6
    lock_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && (wr_addr == A_LOCK_SET || wr_addr == A_LOCK_CLR))) |=> $stable(status[NUM_CH+1]));

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_force_chk
        // R8
        pattern_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pat_act[o] |-> (wave[o] == pat_act[NUM_OUT+o]));
    end
endmodule

// File: tb/test_pwm_shadow_pattern.sv
module test_pwm_shadow_pattern;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int NOUT = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [NCH+1:0] status;
    logic [NOUT-1:0] wave;

    int checks = 0;
    int errors = 0;

    // {compare value, expected high clocks per 10-clock cycle}
    localparam logic [23:0] VEC [6] = '{
        {16'd0,   8'd0},
        {16'd1,   8'd1},
        {16'd5,   8'd5},
        {16'd9,   8'd9},
        {16'd10,  8'd10},
        {16'd200, 8'd10}
    };

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_shadow_pattern #(.CNT_W(16), .NUM_CH(NCH), .NUM_OUT(NOUT)) i_pwm_shadow_pattern (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .status  (status),
        .wave    (wave)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wait_count(input logic [15:0] v);
        logic [15:0] c;
        for (int i = 0; i < 1000; i++) begin
            rd(4'h6, c);
            if (c == v) break;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v;
        int n, highs;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        rd(4'h0, v); chk("R11 period", v, 0);
        rd(4'h4, v); chk("R11 override", v, 0);
        rd(4'h8, v); chk("R11 compare0", v, 0);
        chk("R11 status", status, 0);
        chk("R11 wave", wave, 0);

        // R12 readback
        wr(4'h0, 16'd9);
        rd(4'h0, v); chk("R12 period", v, 9);
        wr(4'hD, 16'h0044);
        rd(4'hD, v); chk("R12 compare1 shadow", v, 16'h0044);
        wr(4'h8, 16'd0);
        wr(4'hD, 16'd0);
        repeat (12) @(negedge clk);

        // R1 cycle length
        wait_count(0);
        n = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk); n++;
            rd(4'h6, v);
            if (v == 0) break;
        end
        chk("R1 cycle length P=9", n, 10);
        wr(4'h0, 16'd3);
        wait_count(0);
        n = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk); n++;
            rd(4'h6, v);
            if (v == 0) break;
        end
        chk("R1 cycle length P=3", n, 4);
        wr(4'h0, 16'd9);

        // R2 duty table
        foreach (VEC[k]) begin
            wr(4'h8, VEC[k][23:8]);
            wait_count(0);
            highs = 0;
            for (int i = 0; i < 10; i++) begin
                if (wave[0]) highs++;
                @(negedge clk);
            end
            chk("R2 high clocks", highs, VEC[k][7:0]);
        end
        wr(4'h8, 16'd0);

        // R3 / R4 shadows commit together
        wait_count(0);
        wr(4'hC, 16'd3);
        wr(4'hD, 16'd7);
        wr(4'h5, 16'h0212);
        chk("R3 pending bits", status, 6'b010011);
        rd(4'h8, v); chk("R3 active unchanged", v, 0);
        wait_count(9);
        rd(4'h8, v); chk("R4 active before wrap", v, 0);
        @(negedge clk);
        rd(4'h6, v); chk("R4 count at wrap", v, 0);
        rd(4'h8, v); chk("R4 compare0 committed", v, 3);
        rd(4'h9, v); chk("R4 compare1 committed", v, 7);
        rd(4'h4, v); chk("R4 override committed", v, 16'h0212);
        chk("R4 pending cleared", status, 0);
        chk("R8 wave0 from pwm", wave[0], 1);
        chk("R8 wave4 forced low", wave[4], 0);
        wait_count(8);
        chk("R8 wave1 forced high", wave[1], 1);
        chk("R9 wave5 follows ch1", wave[5], 0);

        // R6 lock control
        wr(4'h2, 16'h0000);
        chk("R6 set with 0 ignored", status[NCH+1], 0);
        wr(4'h2, 16'h0001);
        chk("R6 lock set", status[NCH+1], 1);
        wr(4'h3, 16'h0000);
        chk("R6 clear with 0 ignored", status[NCH+1], 1);

        // R7 locked wrap
        wait_count(0);
        wr(4'hC, 16'd6);
        wait_count(9);
        @(negedge clk);
        rd(4'h8, v); chk("R7 no transfer while locked", v, 3);
        chk("R7 pending kept", status[0], 1);
        wr(4'h3, 16'h0001);
        chk("R6 lock cleared", status[NCH+1], 0);
        wait_count(9);
        @(negedge clk);
        rd(4'h8, v); chk("R7 commit after unlock", v, 6);
        chk("R7 pending cleared", status[0], 0);

        // R10 / R5 direct writes
        wr(4'hA, 16'd4);
        rd(4'hA, v); chk("R10 direct compare", v, 4);
        wait_count(9);
        @(negedge clk);
        rd(4'hA, v); chk("R5 held across wrap", v, 4);
        wr(4'h4, 16'h8080);
        chk("R10 direct override", wave[7], 1);
        rd(4'h5, v); chk("R10 shadow untouched", v, 16'h0212);
        wr(4'h4, 16'h0000);

        // R9 routing
        wait_count(6);
        chk("R9 unrouted low/high mix", {wave[5], wave[4], wave[1], wave[0]}, 4'b1010);
        wr(4'h1, 16'h0001);
        wait_count(6);
        chk("R9 routed low", wave, 8'h00);
        wait_count(3);
        chk("R9 routed high", wave, 8'hFF);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule